// File: doc/BRIEF.md
# Reorder Buffer Retire Controller

This block sits at the tail of an out-of-order pipeline and decides, every cycle, which of the oldest reorder-buffer entries leave the machine. The buffer presents up to `W` head candidates in age order, each with a thread number and its status bits. The controller walks these candidates from oldest to youngest and retires a contiguous prefix of them. It stops at the first candidate that cannot leave.

Three kinds of unexecuted head are not retired. Serialising instructions (non-speculative, store-conditional or barrier), uncached loads and faulting instructions must be the first instruction committed in a cycle, and no stores may be waiting for writeback. When these conditions hold, the block issues a request to execute the instruction or starts a trap countdown for its thread.

The block also returns occupancy information to the earlier stages: a free-entry count whenever occupancy changes, and an empty indication that is held back in any cycle where a store commits. It keeps a program counter per thread, a histogram of instructions committed per cycle, and a count of cycles in which the full width was used.

Top module: `commit_retire`

## Requirements
- R1: The retired slots always form a contiguous run starting at slot 0. The walk stops at the first slot that is not selected (`slotValid`=0), not ready (`slotReady`=0), belongs to a thread with a trap pending, or is a faulting or unexecuted non-squashed head.
- R2: `fullWidthCycles` increases by exactly one after each cycle in which `commitCount` equals `W`. In all other cycles it keeps its value.
- R3: A squashed head at the walk position is removed: its `retireMask` bit is set. It does not count toward `commitCount`, which counts only retired non-squashed slots.
- R4: An unexecuted head with `slotNonSpec`=1 (non-speculative, store-conditional or barrier) raises `nsReqValid` with its sequence number on `nsReqSeq`. This happens only if no instruction has committed earlier in the same cycle and `storesPending`=0. In every case the head stalls the walk.
- R5: An unexecuted head with `slotNonSpec`=0 and `slotLoad`=1 raises `uncachedReq` under the same first-commit and no-pending-store rule. In every case it stalls the walk.
- R6: A faulting head (`slotFault`=1, checked before the executed bit) raises `trapStart` with `trapTid` under the same rule, and is never retired. The thread's `trapPending` bit is set from the next cycle for `TRAP_LAT` cycles. `trapFire` pulses in the last of those cycles.
- R7: `doneValid` is high when at least one instruction commits in the cycle. `doneSeq` carries the sequence number of the youngest instruction committed in that cycle.
- R8: Each thread's program counter in `pcOut` (reset value 0) advances on the next clock edge by `INST_BYTES` times the number of that thread's instructions committed in the cycle.
- R9: `emptyReport` is high exactly when `robCount` equals the number of entries removed this cycle, `storesPending`=0, and no committed slot has `slotStore`=1.
- R10: `freeValid` is high when any entry is removed. `freeCount` always equals `DEPTH - robCount + removed`.
- R11: Histogram bin k (`histCount` slice k, for k = 0..W) increases by one after every cycle in which `commitCount` equals k.
- R12: After reset, `pcOut`, `histCount`, `fullWidthCycles` and `trapPending` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slotValid | input | W | A thread is selected for this slot |
| slotTid | input | W x TIDW | Thread of each slot |
| slotReady | input | W | Head entry present and ready |
| slotSquashed | input | W | Head was squashed |
| slotExecuted | input | W | Head has executed |
| slotNonSpec | input | W | Non-speculative, store-conditional or barrier |
| slotLoad | input | W | Head is a load |
| slotStore | input | W | Head is a store |
| slotFault | input | W | Head carries a fault |
| slotSeq | input | W x SEQW | Sequence number of each head |
| storesPending | input | 1 | Stores are awaiting writeback |
| robCount | input | OCCW | Buffer occupancy before this cycle's removal |
| retireMask | output | W | Slots removed this cycle |
| commitCount | output | CNTW | Non-squashed instructions committed |
| doneValid | output | 1 | Some instruction committed |
| doneSeq | output | SEQW | Youngest committed sequence number |
| nsReqValid | output | 1 | Non-speculative execution request; clears the head's can-commit flag |
| nsReqSeq | output | SEQW | Sequence number for that request |
| uncachedReq | output | 1 | Uncached load request |
| trapStart | output | 1 | Trap countdown begins |
| trapTid | output | TIDW | Thread taking the trap |
| trapPending | output | NT | Per-thread trap in progress |
| trapFire | output | NT | Per-thread trap countdown expiry pulse |
| freeValid | output | 1 | Free-entry report valid |
| freeCount | output | OCCW | Free entries after removal |
| emptyReport | output | 1 | Buffer reported empty to earlier stages |
| pcOut | output | NT x PCW | Per-thread committed program counter |
| histCount | output | (W+1) x HW | Per-cycle commit histogram |
| fullWidthCycles | output | HW | Cycles with full-width commit |

## Verification
The properties assume that `robCount` is never below the number of entries the walk can remove. They also assume that `slotTid` names an existing thread and that the counters do not wrap during a run. The stimulus derives `robCount` from the length of the leading run of selected, ready slots, optionally adding slack, so removal can never exceed occupancy; zero slack is chosen often enough to exercise the empty report. The configuration has two threads and a one-bit thread field, so every thread number is legal. The run is far shorter than the 16-bit counter range.

// File: rtl/commit_pkg.sv
package commit_pkg;
  typedef struct packed {
    logic anyRemoved;
    logic storeCommitted;
    logic fullWidth;
    logic trapStart;
  } retireStrobe_t;
endpackage

// File: rtl/commit_ctrl.sv
module commit_ctrl
  import commit_pkg::*;
#(
  parameter int W        = 4,
  parameter int NT       = 2,
  parameter int SEQW     = 16,
  parameter int TRAP_LAT = 3,
  localparam int TIDW    = (NT > 1) ? $clog2(NT) : 1,
  localparam int CNTW    = $clog2(W + 1),
  localparam int TCW     = $clog2(TRAP_LAT + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [W-1:0]              slotValid,
  input  logic [W-1:0][TIDW-1:0]    slotTid,
  input  logic [W-1:0]              slotReady,
  input  logic [W-1:0]              slotSquashed,
  input  logic [W-1:0]              slotExecuted,
  input  logic [W-1:0]              slotNonSpec,
  input  logic [W-1:0]              slotLoad,
  input  logic [W-1:0]              slotStore,
  input  logic [W-1:0]              slotFault,
  input  logic [W-1:0][SEQW-1:0]    slotSeq,
  input  logic                      storesPending,
  output logic [W-1:0]              retireMask,
  output logic [W-1:0]              commitMask,
  output logic [CNTW-1:0]           commitCount,
  output logic [CNTW-1:0]           removedCount,
  output logic                      nsReqValid,
  output logic [SEQW-1:0]           nsReqSeq,
  output logic                      uncachedReq,
  output logic [TIDW-1:0]           trapTid,
  output logic [NT-1:0]             trapPending,
  output logic [NT-1:0]             trapFire,
  output retireStrobe_t             strobe
);
  logic [NT-1:0]          pendQ;
  logic [NT-1:0][TCW-1:0] cntQ;

  // Age-ordered walk over the head candidates
  always_comb begin
    logic alive;
    logic serialOk;
    retireMask   = '0;
    commitMask   = '0;
    commitCount  = '0;
    removedCount = '0;
    nsReqValid   = 1'b0;
    nsReqSeq     = '0;
    uncachedReq  = 1'b0;
    trapTid      = '0;
    strobe       = '0;
    alive        = 1'b1;
    for (int i = 0; i < W; i++) begin
      serialOk = (commitCount == '0) && !storesPending;
      if (alive) begin
        if (!slotValid[i] || !slotReady[i]) begin
          alive = 1'b0;
        end else if (slotSquashed[i]) begin
          retireMask[i] = 1'b1;
          removedCount  = removedCount + CNTW'(1);
        end else if (pendQ[slotTid[i]]) begin
          alive = 1'b0;
        end else if (slotFault[i]) begin
          if (serialOk) begin
            strobe.trapStart = 1'b1;
            trapTid          = slotTid[i];
          end
          alive = 1'b0;
        end else if (!slotExecuted[i]) begin
          if (slotNonSpec[i] && serialOk) begin
            nsReqValid = 1'b1;
            nsReqSeq   = slotSeq[i];
          end else if (!slotNonSpec[i] && slotLoad[i] && serialOk) begin
            uncachedReq = 1'b1;
          end
          alive = 1'b0;
        end else begin
          retireMask[i] = 1'b1;
          commitMask[i] = 1'b1;
          commitCount   = commitCount + CNTW'(1);
          removedCount  = removedCount + CNTW'(1);
          if (slotStore[i]) strobe.storeCommitted = 1'b1;
        end
      end
    end
    strobe.anyRemoved = (removedCount != '0);
    strobe.fullWidth  = (commitCount == CNTW'(W));
  end

  // Per-thread trap countdown
  for (genvar t = 0; t < NT; t++) begin : g_trap
    assign trapFire[t] = pendQ[t] && (cntQ[t] == '0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pendQ[t] <= 1'b0;
        cntQ[t]  <= '0;
      end else if (strobe.trapStart && (trapTid == TIDW'(t))) begin
        pendQ[t] <= 1'b1;
        cntQ[t]  <= TCW'(TRAP_LAT - 1);
      end else if (trapFire[t]) begin
        pendQ[t] <= 1'b0;
      end else if (pendQ[t]) begin
        cntQ[t] <= cntQ[t] - TCW'(1);
      end
    end
  end

  assign trapPending = pendQ;
endmodule

// File: rtl/commit_dp.sv
module commit_dp
  import commit_pkg::*;
#(
  parameter int W          = 4,
  parameter int NT         = 2,
  parameter int SEQW       = 16,
  parameter int PCW        = 32,
  parameter int INST_BYTES = 4,
  parameter int DEPTH      = 16,
  parameter int HW         = 16,
  localparam int TIDW      = (NT > 1) ? $clog2(NT) : 1,
  localparam int CNTW      = $clog2(W + 1),
  localparam int OCCW      = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [W-1:0]              commitMask,
  input  logic [W-1:0][TIDW-1:0]    slotTid,
  input  logic [W-1:0][SEQW-1:0]    slotSeq,
  input  logic [CNTW-1:0]           commitCount,
  input  logic [CNTW-1:0]           removedCount,
  input  logic                      storesPending,
  input  logic [OCCW-1:0]           robCount,
  input  retireStrobe_t             strobe,
  output logic                      doneValid,
  output logic [SEQW-1:0]           doneSeq,
  output logic                      freeValid,
  output logic [OCCW-1:0]           freeCount,
  output logic                      emptyReport,
  output logic [NT-1:0][PCW-1:0]    pcOut,
  output logic [W:0][HW-1:0]        histCount,
  output logic [HW-1:0]             fullWidthCycles
);
  logic [NT-1:0][CNTW-1:0] threadCnt;

  always_comb begin
    doneSeq   = '0;
    threadCnt = '0;
    for (int i = 0; i < W; i++) begin
      if (commitMask[i]) begin
        doneSeq = slotSeq[i];
        for (int t = 0; t < NT; t++)
          if (slotTid[i] == TIDW'(t)) threadCnt[t] = threadCnt[t] + CNTW'(1);
      end
    end
  end

  assign doneValid   = (commitCount != '0);
  assign freeValid   = strobe.anyRemoved;
  assign freeCount   = OCCW'((OCCW + 1)'(DEPTH) - (OCCW + 1)'(robCount) + (OCCW + 1)'(removedCount));
  assign emptyReport = (robCount == OCCW'(removedCount)) && !storesPending && !strobe.storeCommitted;

  for (genvar t = 0; t < NT; t++) begin : g_pc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pcOut[t] <= '0;
      else        pcOut[t] <= pcOut[t] + PCW'(threadCnt[t]) * PCW'(INST_BYTES);
    end
  end

  for (genvar k = 0; k <= W; k++) begin : g_hist
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) histCount[k] <= '0;
      else if (commitCount == CNTW'(k)) histCount[k] <= histCount[k] + HW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                fullWidthCycles <= '0;
    else if (strobe.fullWidth) fullWidthCycles <= fullWidthCycles + HW'(1);
  end
endmodule

// File: rtl/commit_retire.sv
module commit_retire
  import commit_pkg::*;
#(
  parameter int W          = 4,
  parameter int NT         = 2,
  parameter int SEQW       = 16,
  parameter int PCW        = 32,
  parameter int INST_BYTES = 4,
  parameter int DEPTH      = 16,
  parameter int HW         = 16,
  parameter int TRAP_LAT   = 3,
  localparam int TIDW      = (NT > 1) ? $clog2(NT) : 1,
  localparam int CNTW      = $clog2(W + 1),
  localparam int OCCW      = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [W-1:0]              slotValid,
  input  logic [W-1:0][TIDW-1:0]    slotTid,
  input  logic [W-1:0]              slotReady,
  input  logic [W-1:0]              slotSquashed,
  input  logic [W-1:0]              slotExecuted,
  input  logic [W-1:0]              slotNonSpec,
  input  logic [W-1:0]              slotLoad,
  input  logic [W-1:0]              slotStore,
  input  logic [W-1:0]              slotFault,
  input  logic [W-1:0][SEQW-1:0]    slotSeq,
  input  logic                      storesPending,
  input  logic [OCCW-1:0]           robCount,
  output logic [W-1:0]              retireMask,
  output logic [CNTW-1:0]           commitCount,
  output logic                      doneValid,
  output logic [SEQW-1:0]           doneSeq,
  output logic                      nsReqValid,
  output logic [SEQW-1:0]           nsReqSeq,
  output logic                      uncachedReq,
  output logic                      trapStart,
  output logic [TIDW-1:0]           trapTid,
  output logic [NT-1:0]             trapPending,
  output logic [NT-1:0]             trapFire,
  output logic                      freeValid,
  output logic [OCCW-1:0]           freeCount,
  output logic                      emptyReport,
  output logic [NT-1:0][PCW-1:0]    pcOut,
  output logic [W:0][HW-1:0]        histCount,
  output logic [HW-1:0]             fullWidthCycles
);
  retireStrobe_t   strobe;
  logic [W-1:0]    commitMask;
  logic [CNTW-1:0] removedCount;

  commit_ctrl #(.W(W), .NT(NT), .SEQW(SEQW), .TRAP_LAT(TRAP_LAT)) u_ctrl (
    .clk, .rst_n, .slotValid, .slotTid, .slotReady, .slotSquashed,
    .slotExecuted, .slotNonSpec, .slotLoad, .slotStore, .slotFault, .slotSeq,
    .storesPending, .retireMask, .commitMask, .commitCount, .removedCount,
    .nsReqValid, .nsReqSeq, .uncachedReq, .trapTid, .trapPending, .trapFire,
    .strobe
  );

  commit_dp #(.W(W), .NT(NT), .SEQW(SEQW), .PCW(PCW), .INST_BYTES(INST_BYTES),
              .DEPTH(DEPTH), .HW(HW)) u_dp (
    .clk, .rst_n, .commitMask, .slotTid, .slotSeq, .commitCount, .removedCount,
    .storesPending, .robCount, .strobe, .doneValid, .doneSeq, .freeValid,
    .freeCount, .emptyReport, .pcOut, .histCount, .fullWidthCycles
  );

  assign trapStart = strobe.trapStart;
endmodule

// File: rtl/commit_retire_chk.sv
module commit_retire_chk #(
  parameter int W    = 4,
  parameter int NT   = 2,
  parameter int HW   = 16,
  parameter int CNTW = 3,
  parameter int TIDW = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [W-1:0]    retireMask,
  input logic [CNTW-1:0] commitCount,
  input logic            storesPending,
  input logic            nsReqValid,
  input logic            uncachedReq,
  input logic            trapStart,
  input logic [TIDW-1:0] trapTid,
  input logic [NT-1:0]   trapPending,
  input logic            emptyReport,
  input logic            freeValid,
  input logic [HW-1:0]   fullWidthCycles
);
  assert_prefix_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (retireMask & ~((retireMask << 1) | W'(1))) == '0);

  assert_full_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (commitCount == CNTW'(W)) |=> (fullWidthCycles == $past(fullWidthCycles) + HW'(1)));

  assert_squash_uncounted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(commitCount) <= $countones(retireMask));

  assert_ns_no_stores_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nsReqValid |-> !storesPending);

  assert_unc_no_stores_R5: assert property (@(posedge clk) disable iff (!rst_n)
    uncachedReq |-> !storesPending);

  assert_trap_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trapStart |=> trapPending[$past(trapTid)]);

  assert_single_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trapStart, nsReqValid, uncachedReq}));

  assert_empty_no_stores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    emptyReport |-> !storesPending);

  assert_free_on_removal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (retireMask != '0) |-> freeValid);
endmodule

bind commit_retire commit_retire_chk #(.W(W), .NT(NT), .HW(HW), .CNTW(CNTW), .TIDW(TIDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .retireMask(retireMask), .commitCount(commitCount),
  .storesPending(storesPending), .nsReqValid(nsReqValid), .uncachedReq(uncachedReq),
  .trapStart(trapStart), .trapTid(trapTid), .trapPending(trapPending),
  .emptyReport(emptyReport), .freeValid(freeValid), .fullWidthCycles(fullWidthCycles)
);

// File: tb/commit_retire_tb.sv
module commit_retire_tb;
  localparam int W = 4, NT = 2, SEQW = 16, PCW = 32, IB = 4, DEPTH = 16, HW = 16, TL = 3;
  localparam int TIDW = 1, CNTW = 3, OCCW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] vV, vR, vS, vE, vN, vL, vSt, vF;
  logic [W-1:0][TIDW-1:0] vT;
  logic [W-1:0][SEQW-1:0] vQ;
  logic sp;
  logic [OCCW-1:0] rc;

  logic [W-1:0] retireMask;
  logic [CNTW-1:0] commitCount;
  logic doneValid, nsReqValid, uncachedReq, trapStart, freeValid, emptyReport;
  logic [SEQW-1:0] doneSeq, nsReqSeq;
  logic [TIDW-1:0] trapTid;
  logic [NT-1:0] trapPending, trapFire;
  logic [OCCW-1:0] freeCount;
  logic [NT-1:0][PCW-1:0] pcOut;
  logic [W:0][HW-1:0] histCount;
  logic [HW-1:0] fullWidthCycles;

  commit_retire #(.W(W), .NT(NT), .SEQW(SEQW), .PCW(PCW), .INST_BYTES(IB),
                  .DEPTH(DEPTH), .HW(HW), .TRAP_LAT(TL)) u_dut (
    .clk, .rst_n, .slotValid(vV), .slotTid(vT), .slotReady(vR), .slotSquashed(vS),
    .slotExecuted(vE), .slotNonSpec(vN), .slotLoad(vL), .slotStore(vSt),
    .slotFault(vF), .slotSeq(vQ), .storesPending(sp), .robCount(rc),
    .retireMask, .commitCount, .doneValid, .doneSeq, .nsReqValid, .nsReqSeq,
    .uncachedReq, .trapStart, .trapTid, .trapPending, .trapFire, .freeValid,
    .freeCount, .emptyReport, .pcOut, .histCount, .fullWidthCycles
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference state
  int mPend[NT], mCnt[NT];
  longint mPc[NT];
  int mHist[W+1];
  int mFull;
  // expected outputs for the current cycle
  logic [W-1:0] eMask;
  int eCommit, eRemoved, eTid;
  bit eDone, eNs, eUnc, eTrap, eStoreC;
  int eDoneSeq, eNsSeq;
  int eThr[NT];

  task automatic model();
    bit alive = 1;
    bit ok;
    eMask = '0; eCommit = 0; eRemoved = 0; eTid = 0; eDoneSeq = 0; eNsSeq = 0;
    eNs = 0; eUnc = 0; eTrap = 0; eStoreC = 0;
    for (int t = 0; t < NT; t++) eThr[t] = 0;
    for (int i = 0; i < W; i++) begin
      ok = (eCommit == 0) && !sp;
      if (!alive) continue;
      if (!vV[i] || !vR[i]) alive = 0;
      else if (vS[i]) begin eMask[i] = 1; eRemoved++; end
      else if (mPend[vT[i]] != 0) alive = 0;
      else if (vF[i]) begin
        if (ok) begin eTrap = 1; eTid = int'(vT[i]); end
        alive = 0;
      end else if (!vE[i]) begin
        if (vN[i] && ok) begin eNs = 1; eNsSeq = int'(vQ[i]); end
        else if (!vN[i] && vL[i] && ok) eUnc = 1;
        alive = 0;
      end else begin
        eMask[i] = 1; eCommit++; eRemoved++;
        eDoneSeq = int'(vQ[i]);
        eThr[vT[i]]++;
        if (vSt[i]) eStoreC = 1;
      end
    end
    eDone = (eCommit > 0);
  endtask

  task automatic checkAll();
    bit fire;
    chk(retireMask == eMask, "R1", "retireMask", retireMask, eMask);
    chk(int'(commitCount) == eCommit, "R3", "commitCount", commitCount, eCommit);
    chk(doneValid == eDone && (!eDone || int'(doneSeq) == eDoneSeq), "R7", "doneSeq",
        {doneValid, doneSeq}, {eDone, eDoneSeq[15:0]});
    chk(nsReqValid == eNs && (!eNs || int'(nsReqSeq) == eNsSeq), "R4", "nsReq",
        {nsReqValid, nsReqSeq}, {eNs, eNsSeq[15:0]});
    chk(uncachedReq == eUnc, "R5", "uncachedReq", uncachedReq, eUnc);
    chk(trapStart == eTrap && (!eTrap || int'(trapTid) == eTid), "R6", "trapStart",
        {trapStart, trapTid}, {eTrap, eTid[0]});
    for (int t = 0; t < NT; t++) begin
      fire = (mPend[t] != 0) && (mCnt[t] == 0);
      chk(trapPending[t] == (mPend[t] != 0) && trapFire[t] == fire, "R6", "trapPending/Fire",
          {trapPending[t], trapFire[t]}, {mPend[t] != 0, fire});
      chk(longint'(pcOut[t]) == mPc[t], "R8", "pcOut", pcOut[t], mPc[t]);
    end
    chk(freeValid == (eRemoved > 0) && int'(freeCount) == DEPTH - int'(rc) + eRemoved,
        "R10", "freeCount", freeCount, DEPTH - int'(rc) + eRemoved);
    chk(emptyReport == ((int'(rc) == eRemoved) && !sp && !eStoreC), "R9", "emptyReport",
        emptyReport, (int'(rc) == eRemoved) && !sp && !eStoreC);
    for (int k = 0; k <= W; k++)
      chk(int'(histCount[k]) == mHist[k], "R11", "histCount", histCount[k], mHist[k]);
    chk(int'(fullWidthCycles) == mFull, "R2", "fullWidthCycles", fullWidthCycles, mFull);
  endtask

  task automatic advance();
    for (int t = 0; t < NT; t++) begin
      if (eTrap && eTid == t) begin mPend[t] = 1; mCnt[t] = TL - 1; end
      else if (mPend[t] != 0 && mCnt[t] == 0) mPend[t] = 0;
      else if (mPend[t] != 0) mCnt[t]--;
      mPc[t] += longint'(eThr[t]) * IB;
    end
    mHist[eCommit]++;
    if (eCommit == W) mFull++;
  endtask

  task automatic randStim(input int mode);
    int lead;
    for (int i = 0; i < W; i++) begin
      vV[i]  = ($urandom % 100) < 90;
      vR[i]  = ($urandom % 100) < 85;
      vS[i]  = ($urandom % 100) < 12;
      vE[i]  = ($urandom % 100) < (mode == 0 ? 85 : 60);
      vN[i]  = ($urandom % 100) < 15;
      vL[i]  = ($urandom % 100) < 35;
      vSt[i] = ($urandom % 100) < 30;
      vF[i]  = ($urandom % 100) < (mode == 0 ? 3 : 10);
      vT[i]  = TIDW'($urandom % NT);
      vQ[i]  = SEQW'($urandom);
    end
    sp = ($urandom % 100) < 30;
    lead = 0;
    for (int i = 0; i < W; i++) begin
      if (vV[i] && vR[i] && lead == i) lead++;
    end
    rc = OCCW'(lead + (($urandom % 3 == 0) ? 0 : int'($urandom % 6)));
  endtask

  task automatic clearStim();
    vV = '0; vR = '0; vS = '0; vE = '0; vN = '0; vL = '0; vSt = '0; vF = '0;
    vT = '0; vQ = '0; sp = 1'b0; rc = '0;
  endtask

  task automatic cycle();
    #1;
    model();
    checkAll();
    @(posedge clk);
    advance();
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++) begin mPend[t] = 0; mCnt[t] = 0; mPc[t] = 0; end
    for (int k = 0; k <= W; k++) mHist[k] = 0;
    mFull = 0;
    clearStim();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12: reset state
    chk(pcOut == '0 && histCount == '0 && fullWidthCycles == '0 && trapPending == '0,
        "R12", "reset state", 0, 0);

    // Directed: full width commit of executed stores, then empty deferral (R2, R9)
    vV = '1; vR = '1; vE = '1; vSt = 4'b0010; vT = '0; rc = OCCW'(4);
    for (int i = 0; i < W; i++) vQ[i] = SEQW'(100 + i);
    cycle();
    vSt = '0; rc = '0; vV = '0;
    cycle();
    // Directed: serialising head behind a commit stalls without request (R4)
    vV = 4'b0011; vR = 4'b0011; vE = 4'b0001; vN = 4'b0010; rc = OCCW'(2);
    cycle();
    // Directed: same head first, no stores pending (R4), then with stores (R4)
    vE = 4'b0000; vN = 4'b0001;
    cycle();
    sp = 1'b1;
    cycle();
    // Directed: uncached load (R5), fault and trap countdown (R6)
    sp = 1'b0; vN = '0; vL = 4'b0001;
    cycle();
    vL = '0; vF = 4'b0001; vT[0] = 1'b1;
    cycle();
    vF = '0; vE = '1; vT = '1;
    repeat (TL + 1) cycle();
    // Directed: squashed heads only (R3, R10)
    vS = 4'b0011; vE = '0;
    cycle();

    for (int n = 0; n < 4000; n++) begin
      randStim(n % 2);
      cycle();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule